// File: doc/BRIEF.md
# Vectored Interrupt Classifier and Dispatcher

This block collects 32 interrupt request lines and sorts each into one of three classes at run time. A line marked fast goes straight to a dedicated fast-interrupt output and never touches the vector logic. Any other enabled line is a normal interrupt. It is vectored when one of 16 priority slots names it as its source. It is non-vectored when no enabled slot claims it. Each slot carries its own handler address. All non-vectored lines share one default handler address.

Software sees the block through a small word-addressed register port. Reads return data combinationally in the same cycle. Writes and read side effects take hold at the rising clock edge. The handler reads the vector register to get the address to jump to. That read also marks the granted level as in service, which blocks that level and every lower one. Only higher-priority slots can then nest. A write to the end-of-service register releases the most recently entered level. The register port is plain control traffic with one access per cycle, so it has no valid/ready handshake and no back-pressure.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every writable register reads 0, `irq_o` and `fiq_o` are low, and a vector read (offset 6) returns 0.
- R2: The raw status register (offset 0) reads as the OR of `irq_src_i` and the software-force register (offset 5, read/write). Setting a force bit raises that line even when the input is low.
- R3: `fiq_o` is high exactly when some line is raw-asserted, enabled (offset 3) and marked fast in the class register (offset 4, bit = 1 means fast). A fast line never raises `irq_o`. The fast status register (offset 2) reads raw & enable & class.
- R4: A slot is written through control offset 0x10+n (bit 5 enable, bits 4:0 source number) and address offset 0x20+n. An enabled slot whose source is enabled, normal-class and raw-asserted raises `irq_o`. A vector read returns that slot's address, and the lowest-numbered requesting slot wins.
- R5: An enabled, normal-class, asserted line that no enabled slot names is non-vectored. It raises `irq_o`, and a vector read returns the default address (offset 8) when no slot is requesting.
- R6: A vector read that returns a live request puts that level in service. Slot n masks slots n and above and all non-vectored lines. The default level masks only non-vectored lines. Higher-priority slots still raise `irq_o` and nest.
- R7: Any write to the end-of-service register (offset 7) releases the highest-priority level in service, so the masked requests again raise `irq_o`.
- R8: A line whose enable bit is 0 raises neither output. A slot whose enable bit is 0 does not claim its source, so that line becomes non-vectored.
- R9: A vector read while `irq_o` is low returns the default address and changes no service state.
- R10: The normal-interrupt status register (offset 1) reads raw & enable & ~class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Interrupt request lines, level sensitive |
| reg_addr_i | input | 6 | Register word offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe (needed for vector-read side effect) |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The bench nests a high-priority slot inside a low one and releases the levels one at a time. A tracker that cleared every level on release would re-raise the lower slot too early. One that cleared the wrong bit would leave the high slot masked. It reads the vector with two slots pending, checking that the lower-numbered slot wins over the order of assertion. It also checks that a slot beats the default address while the default level is in service. It turns a slot off to show that its line falls back to the default address. It reads an idle vector and then raises a line, which would stay masked if an idle read wrongly entered service. Fast lines are checked for leaking into `irq_o` and for ignoring the enable bit.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] OFS_RAW    = 6'h00;
  localparam logic [REG_AW-1:0] OFS_IRQSTS = 6'h01;
  localparam logic [REG_AW-1:0] OFS_FIQSTS = 6'h02;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 6'h03;
  localparam logic [REG_AW-1:0] OFS_CLASS  = 6'h04;
  localparam logic [REG_AW-1:0] OFS_FORCE  = 6'h05;
  localparam logic [REG_AW-1:0] OFS_VECTOR = 6'h06;
  localparam logic [REG_AW-1:0] OFS_EOS    = 6'h07;
  localparam logic [REG_AW-1:0] OFS_DFLT   = 6'h08;
  localparam logic [1:0] BANK_SLOTCTL = 2'b01;
  localparam logic [1:0] BANK_SLOTVEC = 2'b10;
  localparam int SLOT_EN_BIT = 5;
  localparam int MAX_SLOTS   = 16;
endpackage

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N-1:0] ahead;

  assign ahead[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign ahead[i] = ahead[i-1] | req_i[i-1];
  end
  assign grant_o = req_i & ~ahead;
  assign any_o   = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) idx_o = IDX_W'(i);
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  assert_grant_when_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (grant_o != '0) && ((grant_o & ~req_i) == '0));
endmodule

// File: rtl/ivc_service_track.sv
module ivc_service_track #(
  parameter int LVLS = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            claim_i,
  input  logic [LVLS-1:0] claim_lvl_i,
  input  logic            release_i,
  output logic [LVLS-1:0] allow_o
);
  logic [LVLS-1:0] insvc_q, after_rel, insvc_d;

  always_comb begin
    after_rel = release_i ? (insvc_q & (insvc_q - 1'b1)) : insvc_q;
    insvc_d   = claim_i ? (after_rel | claim_lvl_i) : after_rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insvc_q <= '0;
    else        insvc_q <= insvc_d;
  end

  assign allow_o[0] = ~insvc_q[0];
  for (genvar i = 1; i < LVLS; i++) begin : g_allow
    assign allow_o[i] = allow_o[i-1] & ~insvc_q[i];
  end

  assert_claim_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> ($countones(claim_lvl_i) == 1));
  assert_claim_allowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> ((claim_lvl_i & allow_o) != '0));
  assert_claim_enters_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (insvc_q != '0));
  assert_release_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !claim_i && $countones(insvc_q) == 1) |=> (insvc_q == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic [5:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int IDX_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;
  localparam int LVL_N = NUM_SLOT + 1;

  initial begin
    if (NUM_SLOT > MAX_SLOTS || NUM_SRC > DATA_W)
      $error("irq_vector_ctrl: parameter out of range");
  end

  logic [NUM_SRC-1:0] en_q, cls_q, force_q;
  logic [DATA_W-1:0]  dflt_q;
  logic [NUM_SLOT-1:0] slot_on_q;
  logic [SRC_W-1:0]   slot_src_q [NUM_SLOT];
  logic [DATA_W-1:0]  slot_vec_q [NUM_SLOT];

  logic [3:0] slot_sel;
  logic       ctl_hit, vec_hit;
  assign slot_sel = reg_addr_i[3:0];
  assign ctl_hit  = (reg_addr_i[5:4] == BANK_SLOTCTL);
  assign vec_hit  = (reg_addr_i[5:4] == BANK_SLOTVEC);

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      cls_q     <= '0;
      force_q   <= '0;
      dflt_q    <= '0;
      slot_on_q <= '0;
      for (int i = 0; i < NUM_SLOT; i++) begin
        slot_src_q[i] <= '0;
        slot_vec_q[i] <= '0;
      end
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        OFS_ENABLE: en_q    <= reg_wdata_i[NUM_SRC-1:0];
        OFS_CLASS:  cls_q   <= reg_wdata_i[NUM_SRC-1:0];
        OFS_FORCE:  force_q <= reg_wdata_i[NUM_SRC-1:0];
        OFS_DFLT:   dflt_q  <= reg_wdata_i;
        default: ;
      endcase
      for (int i = 0; i < NUM_SLOT; i++) begin
        if (ctl_hit && slot_sel == 4'(i)) begin
          slot_on_q[i]  <= reg_wdata_i[SLOT_EN_BIT];
          slot_src_q[i] <= reg_wdata_i[SRC_W-1:0];
        end
        if (vec_hit && slot_sel == 4'(i))
          slot_vec_q[i] <= reg_wdata_i;
      end
    end
  end

  // classification
  logic [NUM_SRC-1:0] raw, irq_pend, fiq_pend, claimed;
  assign raw      = irq_src_i | force_q;
  assign irq_pend = raw & en_q & ~cls_q;
  assign fiq_pend = raw & en_q & cls_q;
  assign fiq_o    = |fiq_pend;

  always_comb begin
    claimed = '0;
    for (int i = 0; i < NUM_SLOT; i++)
      if (slot_on_q[i]) claimed[slot_src_q[i]] = 1'b1;
  end

  // priority and service
  logic [LVL_N-1:0]    allow, claim_lvl;
  logic [NUM_SLOT-1:0] slot_req, slot_gnt;
  logic [IDX_W-1:0]    gnt_idx;
  logic                slot_any, nonvec_req, claim, eos;

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot_req
    assign slot_req[i] = slot_on_q[i] & irq_pend[slot_src_q[i]] & allow[i];
  end

  ivc_prio_pick #(.N(NUM_SLOT), .IDX_W(IDX_W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (slot_req),
    .grant_o (slot_gnt),
    .idx_o   (gnt_idx),
    .any_o   (slot_any)
  );

  assign nonvec_req = (|(irq_pend & ~claimed)) & allow[NUM_SLOT];
  assign irq_o      = slot_any | nonvec_req;
  assign claim      = reg_rd_i && (reg_addr_i == OFS_VECTOR) && irq_o;
  assign eos        = reg_wr_i && (reg_addr_i == OFS_EOS);
  assign claim_lvl  = slot_any ? {1'b0, slot_gnt} : {1'b1, {NUM_SLOT{1'b0}}};

  ivc_service_track #(.LVLS(LVL_N)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim_i     (claim),
    .claim_lvl_i (claim_lvl),
    .release_i   (eos),
    .allow_o     (allow)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_RAW:    reg_rdata_o = DATA_W'(raw);
      OFS_IRQSTS: reg_rdata_o = DATA_W'(irq_pend);
      OFS_FIQSTS: reg_rdata_o = DATA_W'(fiq_pend);
      OFS_ENABLE: reg_rdata_o = DATA_W'(en_q);
      OFS_CLASS:  reg_rdata_o = DATA_W'(cls_q);
      OFS_FORCE:  reg_rdata_o = DATA_W'(force_q);
      OFS_VECTOR: reg_rdata_o = slot_any ? slot_vec_q[gnt_idx] : dflt_q;
      OFS_DFLT:   reg_rdata_o = dflt_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (ctl_hit && slot_sel == 4'(i))
        reg_rdata_o = DATA_W'({slot_on_q[i], slot_src_q[i]});
      if (vec_hit && slot_sel == 4'(i))
        reg_rdata_o = slot_vec_q[i];
    end
  end

  assert_irq_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_pend != '0));
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_o && !fiq_o));
  assert_fast_needs_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (cls_q != '0));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src_i = '0;
  logic [5:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic        reg_rd_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, fiq_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0;
    #1;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irq_src_i = v;
    #1;
  endtask

  task automatic t_reset;
    check("R1 irq", 32'(irq_o), 0);
    check("R1 fiq", 32'(fiq_o), 0);
    rd(6'h03, rv); check("R1 enable", rv, 0);
    rd(6'h08, rv); check("R1 default", rv, 0);
    rd(6'h13, rv); check("R1 slot ctl", rv, 0);
    rd(6'h06, rv); check("R1 vector", rv, 0);
  endtask

  task automatic t_force;
    wr(6'h05, 32'h10);
    rd(6'h00, rv); check("R2 force only", rv, 32'h10);
    drive(32'h8);
    rd(6'h00, rv); check("R2 force|input", rv, 32'h18);
    wr(6'h05, 32'h0);
    rd(6'h00, rv); check("R2 input only", rv, 32'h8);
    drive(0);
  endtask

  task automatic t_fast;
    wr(6'h04, 32'h4);
    wr(6'h03, 32'h4);
    drive(32'h4);
    check("R3 fiq high", 32'(fiq_o), 1);
    check("R3 no irq", 32'(irq_o), 0);
    rd(6'h02, rv); check("R3 fast status", rv, 32'h4);
    wr(6'h03, 32'h0);
    check("R8 fiq off when disabled", 32'(fiq_o), 0);
    drive(0);
  endtask

  task automatic t_masked;
    wr(6'h03, 32'hF);
    wr(6'h04, 32'h2);
    drive(32'h7);
    rd(6'h01, rv); check("R10 normal status", rv, 32'h5);
    rd(6'h02, rv); check("R3 fast status mixed", rv, 32'h2);
    check("R3 fiq mixed", 32'(fiq_o), 1);
    drive(0);
    wr(6'h04, 32'h0);
    wr(6'h03, 32'h0);
  endtask

  task automatic t_vectored;
    wr(6'h10, 32'h20 | 32'd9); wr(6'h20, 32'h1000);
    wr(6'h13, 32'h20 | 32'd4); wr(6'h23, 32'h4000);
    rd(6'h13, rv); check("R4 slot ctl readback", rv, 32'h24);
    wr(6'h03, (32'h1 << 4) | (32'h1 << 9));
    drive(32'h1 << 4);
    check("R4 irq from slot3", 32'(irq_o), 1);
    rd(6'h06, rv); check("R4 vector slot3", rv, 32'h4000);
    check("R6 slot3 masked", 32'(irq_o), 0);
    drive((32'h1 << 4) | (32'h1 << 9));
    check("R6 slot0 nests", 32'(irq_o), 1);
    rd(6'h06, rv); check("R6 nested vector", rv, 32'h1000);
    check("R6 all masked", 32'(irq_o), 0);
    wr(6'h07, 0);
    check("R7 slot0 released", 32'(irq_o), 1);
    drive(32'h1 << 4);
    check("R7 slot3 still held", 32'(irq_o), 0);
    wr(6'h07, 0);
    check("R7 slot3 released", 32'(irq_o), 1);
    drive((32'h1 << 4) | (32'h1 << 9));
    rd(6'h06, rv); check("R4 lower slot wins", rv, 32'h1000);
    wr(6'h07, 0);
    drive(0);
  endtask

  task automatic t_nonvec;
    wr(6'h08, 32'hDEAD0000);
    wr(6'h03, (32'h1 << 4) | (32'h1 << 9) | (32'h1 << 7));
    drive(32'h1 << 7);
    check("R5 irq from unmapped", 32'(irq_o), 1);
    rd(6'h06, rv); check("R5 default vector", rv, 32'hDEAD0000);
    check("R6 default masked", 32'(irq_o), 0);
    drive((32'h1 << 7) | (32'h1 << 4));
    check("R6 slot above default", 32'(irq_o), 1);
    rd(6'h06, rv); check("R5 slot beats default", rv, 32'h4000);
    wr(6'h07, 0);
    wr(6'h07, 0);
    drive(0);
    check("R7 idle after releases", 32'(irq_o), 0);
  endtask

  task automatic t_idle;
    rd(6'h06, rv); check("R9 idle vector", rv, 32'hDEAD0000);
    drive(32'h1 << 4);
    check("R9 no level entered", 32'(irq_o), 1);
    rd(6'h06, rv); check("R9 vector after idle read", rv, 32'h4000);
    wr(6'h07, 0);
    drive(0);
  endtask

  task automatic t_slot_off;
    wr(6'h13, 32'd4);
    drive(32'h1 << 4);
    check("R8 unclaimed line irq", 32'(irq_o), 1);
    rd(6'h06, rv); check("R8 disabled slot falls to default", rv, 32'hDEAD0000);
    wr(6'h07, 0);
    drive(0);
    wr(6'h03, 32'h0);
    drive(32'h1 << 9);
    check("R8 disabled line ignored", 32'(irq_o), 0);
    drive(0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_force;
    t_fast;
    t_masked;
    t_vectored;
    t_nonvec;
    t_idle;
    t_slot_off;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule